// File: doc/BRIEF.md
# Register Hazard Scoreboard

This block keeps track of the destination registers of instructions that decode has issued but that have not yet reached writeback in a short in-order pipeline. Decode inserts each issued instruction's destination. The destination is optional: an instruction that writes no register still takes a slot, marked as carrying no index, so that every insert has exactly one matching remove. Writeback removes the oldest entry once per instruction, and this includes instructions that were squashed.

Three combinational probes compare a source-1 index, a source-2 index and a destination index against the live entries. Decode stalls when any probe reports a hit, which covers read-after-write and write-after-write hazards. Within a cycle, a remove takes effect before probes and inserts. An entry leaving in a cycle therefore produces no hit in that cycle, and its slot can take a new insert at once.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset the scoreboard is empty. `insert_ready` is 1, `remove_ready` is 0, and no probe reports a hit.
- R2: The scoreboard holds at most DEPTH (default 2) entries. While DEPTH entries are held and `remove_valid` is 0, `insert_ready` is 0 and an insert is ignored.
- R3: An insert with `insert_has_dst`=0 still occupies one slot and needs one remove to leave.
- R4: Each probe (source 1, source 2, destination) works on its own. It reports a hit when its valid flag is 1 and a live entry that carries an index holds the same index.
- R5: A probe whose valid flag is 0 never hits. An entry inserted with `insert_has_dst`=0 never matches any probe.
- R6: Register index 0 is compared like any other index.
- R7: A remove always retires the oldest entry (first in, first out).
- R8: An entry removed in a cycle (`remove_valid`=1 and `remove_ready`=1) causes no hit in that cycle.
- R9: When DEPTH entries are held and `remove_valid` is 1, `insert_ready` is 1, and an insert in that cycle is accepted.
- R10: `remove_ready` is 0 exactly when the scoreboard is empty. Issuing a remove while it is empty is a protocol error.
- R11: An inserted entry becomes visible to the probes from the cycle after the insert, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insert_valid | input | 1 | Decode issues an instruction |
| insert_has_dst | input | 1 | The issued instruction writes a register |
| insert_idx | input | IDX_W | Destination register index |
| insert_ready | output | 1 | A slot is free, or is freed this cycle |
| remove_valid | input | 1 | Writeback retires the oldest instruction |
| remove_ready | output | 1 | The scoreboard is not empty |
| src1_vld | input | 1 | Source 1 index is present |
| src1_idx | input | IDX_W | Source 1 index |
| src1_hit | output | 1 | Source 1 hazard |
| src2_vld | input | 1 | Source 2 index is present |
| src2_idx | input | IDX_W | Source 2 index |
| src2_hit | output | 1 | Source 2 hazard |
| dst_vld | input | 1 | Destination probe index is present |
| dst_idx | input | IDX_W | Destination probe index |
| dst_hit | output | 1 | Write-after-write hazard |

## Verification
A remove and an insert, together with the three probes, can all happen in the same cycle. This matters most when the scoreboard is full, where the remove alone decides whether the insert is accepted. A directed case fills both slots, then removes and inserts together while probing the index that is leaving. It expects no hit on that index and an accepted insert. Random traffic then keeps the scoreboard near full and issues removes and inserts together often. Every cycle, the probe outputs and both ready flags are compared with a bench queue model that applies the remove first.

// File: rtl/hazard_sb_pkg.sv
package hazard_sb_pkg;

  // Position of a slot relative to the head of the ring (0 = oldest).
  function automatic int slot_age(input int slot, input int head, input int depth);
    return (slot + depth - head) % depth;
  endfunction

  // Next pointer value in a ring of the given depth.
  function automatic int ring_next(input int ptr, input int depth);
    return (ptr + 1) % depth;
  endfunction

  // Equality of an optional probe against an optional entry.
  function automatic logic opt_match(input logic a_vld, input logic [31:0] a,
                                     input logic b_vld, input logic [31:0] b);
    return a_vld && b_vld && (a == b);
  endfunction

endpackage

// File: rtl/sb_slot_ring.sv
module sb_slot_ring
  import hazard_sb_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ins_fire,
  input  logic                        ins_has_dst,
  input  logic [IDX_W-1:0]            ins_idx,
  input  logic                        rem_fire,
  output logic [DEPTH-1:0]            ent_vld,
  output logic [DEPTH-1:0][IDX_W-1:0] ent_idx,
  output logic [DEPTH-1:0]            live,
  output logic [CNT_W-1:0]            occ_count
);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  assign occ_count = cnt_q;

  // Occupied slots, minus the head when it is being removed this cycle.
  for (genvar s = 0; s < DEPTH; s++) begin : g_live
    logic occupied;
    always_comb begin
      occupied = slot_age(s, int'(head_q), DEPTH) < int'(cnt_q);
      live[s]  = occupied && !(rem_fire && (int'(head_q) == s));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      ent_vld <= '0;
      ent_idx <= '0;
    end else begin
      if (rem_fire) begin
        head_q <= PTR_W'(ring_next(int'(head_q), DEPTH));
      end
      if (ins_fire) begin
        ent_vld[tail_q] <= ins_has_dst;
        ent_idx[tail_q] <= ins_idx;
        tail_q          <= PTR_W'(ring_next(int'(tail_q), DEPTH));
      end
      case ({ins_fire, rem_fire})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/sb_probe.sv
module sb_probe
  import hazard_sb_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int DEPTH = 2
) (
  input  logic                        q_vld,
  input  logic [IDX_W-1:0]            q_idx,
  input  logic [DEPTH-1:0]            live,
  input  logic [DEPTH-1:0]            ent_vld,
  input  logic [DEPTH-1:0][IDX_W-1:0] ent_idx,
  output logic                        hit
);

  logic [DEPTH-1:0] match;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign match[s] = live[s] &&
                      opt_match(q_vld, 32'(q_idx), ent_vld[s], 32'(ent_idx[s]));
  end

  assign hit = |match;

endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int IDX_W = 5,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NPROBE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insert_valid,
  input  logic             insert_has_dst,
  input  logic [IDX_W-1:0] insert_idx,
  output logic             insert_ready,
  input  logic             remove_valid,
  output logic             remove_ready,
  input  logic             src1_vld,
  input  logic [IDX_W-1:0] src1_idx,
  output logic             src1_hit,
  input  logic             src2_vld,
  input  logic [IDX_W-1:0] src2_idx,
  output logic             src2_hit,
  input  logic             dst_vld,
  input  logic [IDX_W-1:0] dst_idx,
  output logic             dst_hit
);

  logic [DEPTH-1:0]            ent_vld;
  logic [DEPTH-1:0][IDX_W-1:0] ent_idx;
  logic [DEPTH-1:0]            live;
  logic [CNT_W-1:0]            occ_count;
  logic                        ins_fire, rem_fire;
  logic [NPROBE-1:0]           pq_vld, phit;
  logic [NPROBE-1:0][IDX_W-1:0] pq_idx;

  // Remove is resolved first; insert sees the slot it frees.
  assign remove_ready = (occ_count != '0);
  assign rem_fire     = remove_valid && remove_ready;
  assign insert_ready = (int'(occ_count) < DEPTH) || rem_fire;
  assign ins_fire     = insert_valid && insert_ready;

  sb_slot_ring #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .ins_fire   (ins_fire),
    .ins_has_dst(insert_has_dst),
    .ins_idx    (insert_idx),
    .rem_fire   (rem_fire),
    .ent_vld    (ent_vld),
    .ent_idx    (ent_idx),
    .live       (live),
    .occ_count  (occ_count)
  );

  assign pq_vld = {dst_vld, src2_vld, src1_vld};
  assign pq_idx = {dst_idx, src2_idx, src1_idx};

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    sb_probe #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_probe (
      .q_vld  (pq_vld[p]),
      .q_idx  (pq_idx[p]),
      .live   (live),
      .ent_vld(ent_vld),
      .ent_idx(ent_idx),
      .hit    (phit[p])
    );
  end

  assign src1_hit = phit[0];
  assign src2_hit = phit[1];
  assign dst_hit  = phit[2];

endmodule

// File: rtl/hazard_scoreboard_chk.sv
module hazard_scoreboard_chk #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             insert_ready,
  input logic             remove_valid,
  input logic             remove_ready,
  input logic             ins_fire,
  input logic             rem_fire,
  input logic [CNT_W-1:0] occ_count,
  input logic             src1_vld,
  input logic             src2_vld,
  input logic             dst_vld,
  input logic             src1_hit,
  input logic             src2_hit,
  input logic             dst_hit
);

  // R10
  remove_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    remove_valid |-> remove_ready);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(occ_count) <= DEPTH);

  // R2
  full_blocks_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(occ_count) == DEPTH && !remove_valid) |-> !insert_ready);

  // R9
  full_remove_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(occ_count) == DEPTH && remove_valid) |-> insert_ready);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> int'(occ_count) ==
      int'($past(occ_count)) + int'($past(ins_fire)) - int'($past(rem_fire)));

  // R5
  invalid_probe_chk: assert property (@(posedge clk) disable iff (rst)
    (!src1_vld |-> !src1_hit) and (!src2_vld |-> !src2_hit) and (!dst_vld |-> !dst_hit));

  // R1
  empty_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (occ_count == '0) |-> !(src1_hit || src2_hit || dst_hit));

endmodule

bind hazard_scoreboard hazard_scoreboard_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .insert_ready(insert_ready),
  .remove_valid(remove_valid),
  .remove_ready(remove_ready),
  .ins_fire    (ins_fire),
  .rem_fire    (rem_fire),
  .occ_count   (occ_count),
  .src1_vld    (src1_vld),
  .src2_vld    (src2_vld),
  .dst_vld     (dst_vld),
  .src1_hit    (src1_hit),
  .src2_hit    (src2_hit),
  .dst_hit     (dst_hit)
);

// File: tb/hazard_scoreboard_tb.sv
module hazard_scoreboard_tb;

  localparam int IDX_W = 5;
  localparam int DEPTH = 2;

  logic clk = 0;
  logic rst = 1;
  logic insert_valid = 0, insert_has_dst = 0, remove_valid = 0;
  logic [IDX_W-1:0] insert_idx = '0;
  logic src1_vld = 0, src2_vld = 0, dst_vld = 0;
  logic [IDX_W-1:0] src1_idx = '0, src2_idx = '0, dst_idx = '0;
  logic insert_ready, remove_ready, src1_hit, src2_hit, dst_hit;

  int errors = 0;
  int checks = 0;

  // Bench model: queue with slot 0 oldest.
  logic m_v [DEPTH];
  int   m_i [DEPTH];
  int   m_n = 0;

  always #5 clk = ~clk;

  hazard_scoreboard #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .insert_valid(insert_valid), .insert_has_dst(insert_has_dst),
    .insert_idx(insert_idx), .insert_ready(insert_ready),
    .remove_valid(remove_valid), .remove_ready(remove_ready),
    .src1_vld(src1_vld), .src1_idx(src1_idx), .src1_hit(src1_hit),
    .src2_vld(src2_vld), .src2_idx(src2_idx), .src2_hit(src2_hit),
    .dst_vld(dst_vld), .dst_idx(dst_idx), .dst_hit(dst_hit)
  );

  function automatic logic exp_hit(input logic qv, input int qi, input logic rem);
    logic h = 0;
    if (!qv) return 0;
    for (int k = 0; k < m_n; k++)
      if (!(rem && k == 0) && m_v[k] && m_i[k] == qi) h = 1;
    return h;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check mid-cycle, update model at posedge.
  task automatic step(input logic ins, input logic hd, input int ii, input logic rem,
                      input logic v1, input int i1, input logic v2, input int i2,
                      input logic vd, input int id, input string tag);
    logic er, ei;
    @(negedge clk);
    insert_valid = ins; insert_has_dst = hd; insert_idx = IDX_W'(ii);
    remove_valid = rem;
    src1_vld = v1; src1_idx = IDX_W'(i1);
    src2_vld = v2; src2_idx = IDX_W'(i2);
    dst_vld  = vd; dst_idx  = IDX_W'(id);
    #2;
    er = rem && (m_n > 0);
    ei = (m_n < DEPTH) || er;
    chk(tag, "remove_ready", remove_ready, m_n > 0);
    chk(tag, "insert_ready", insert_ready, ei);
    chk(tag, "src1_hit", src1_hit, exp_hit(v1, i1, er));
    chk(tag, "src2_hit", src2_hit, exp_hit(v2, i2, er));
    chk(tag, "dst_hit",  dst_hit,  exp_hit(vd, id, er));
    @(posedge clk);
    if (er) begin
      for (int k = 0; k < DEPTH - 1; k++) begin m_v[k] = m_v[k+1]; m_i[k] = m_i[k+1]; end
      m_n--;
    end
    if (ins && ei) begin m_v[m_n] = hd; m_i[m_n] = ii; m_n++; end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0b0a);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 / R10: empty after reset
    step(0,0,0, 0, 1,3, 1,0, 1,31, "R1");
    step(0,0,0, 0, 0,0, 0,0, 0,0, "R10");
    // R11: insert idx 0, same-cycle probe misses
    step(1,1,0, 0, 1,0, 0,0, 1,0, "R11");
    // R6: index 0 now hits on all probes
    step(0,0,0, 0, 1,0, 1,0, 1,0, "R6");
    // R3: insert with no destination fills second slot
    step(1,0,9, 0, 1,9, 0,0, 0,0, "R3");
    // R2 / R5: full, insert refused, invalid probe and invalid entry miss
    step(1,1,4, 0, 0,0, 1,9, 1,4, "R2");
    step(0,0,0, 0, 0,0, 1,9, 0,0, "R5");
    // R8 / R9: remove idx0 while probing it, insert idx 7 together
    step(1,1,7, 1, 1,0, 1,7, 1,0, "R8");
    step(0,0,0, 0, 1,7, 1,0, 0,0, "R9");
    // R7: oldest is the no-destination entry; idx 7 survives its removal
    step(0,0,0, 1, 1,7, 0,0, 1,7, "R7");
    step(0,0,0, 0, 1,7, 0,0, 1,7, "R7");
    step(0,0,0, 1, 0,0, 0,0, 1,7, "R8");
    step(0,0,0, 0, 0,0, 0,0, 1,7, "R10");

    // R4: random traffic on a small index set to force matches
    for (int c = 0; c < 4000; c++) begin
      logic ins, hd, rem;
      ins = ($urandom % 4) != 0;
      hd  = ($urandom % 5) != 0;
      rem = (m_n > 0) && (($urandom % 3) != 0);
      step(ins, hd, int'($urandom % 4), rem,
           ($urandom % 6) != 0, int'($urandom % 4),
           ($urandom % 6) != 0, int'($urandom % 4),
           ($urandom % 6) != 0, int'($urandom % 4), "R4");
    end

    @(negedge clk);
    insert_valid = 0; remove_valid = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule